// File: doc/BRIEF.md
# Banked Nibble Data Memory

This block holds a 4-bit data store of 5120 words, split into 40 banks of 128 words each. Two bank-select registers pick the bank: a 2-bit high field worth 2048 words per step and a 4-bit low field worth 128 words per step. A 4-bit page register chooses one of eight 16-word pages inside the bank. A 4-bit working-register page register places a 16-word window of working registers somewhere in the first 256 words of the same storage.

The block has three access paths, and all three can be used in the same cycle. The direct port gives a 7-bit offset inside the selected bank. The working-register port gives a 4-bit index into the active window. The indirect port names a working register, and the nibble held in that register becomes the lowest address nibble below the bank and page fields. Reads are combinational. Writes land on the rising clock edge. Any composed address at or beyond the end of storage raises an error flag for that port. An out-of-range read returns zero, and an out-of-range write is dropped. Instruction decode, arithmetic and operand selection are left to the surrounding logic.

Top module: `nibble_dmem`

## Requirements
- R1: Direct access addresses word `bank_hi*2048 + bank_lo*128 + dir_off`, and the read value appears on `dir_rdata` in the same cycle.
- R2: Indirect access addresses word `bank_hi*2048 + bank_lo*128 + page[2:0]*16 + V`. V is the 4-bit content of working register `ind_sel`.
- R3: Only bits 2..0 of the page register take part in addressing. Bit 3 is reserved and always reads back as 0 on `pg_rdata`.
- R4: Working-register access addresses word `wr_page*16 + wr_idx`, where `wr_page` is the 4-bit value last loaded through `wrp_we`.
- R5: The working registers and bank 0/1 data words share storage. A write through either view is seen through the other.
- R6: A composed direct or indirect address of 5120 or more sets that port's error flag and returns 0 on read. A write to such an address changes no stored word.
- R7: Reset clears the bank-high, bank-low, page and working-register page registers to 0.
- R8: A read of a word being written in the same cycle returns the old value. The new value is readable from the next cycle.
- R9: When several ports write the same word in one cycle, the working-register port wins over the indirect port, and the indirect port wins over the direct port.
- R10: A register write takes effect at the clock edge. Addresses composed in that cycle still use the previous register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bkh_we | input | 1 | Load bank-high register |
| bkh_wdata | input | 2 | Bank-high value |
| bkl_we | input | 1 | Load bank-low register |
| bkl_wdata | input | 4 | Bank-low value |
| pg_we | input | 1 | Load page register |
| pg_wdata | input | 4 | Page value (bit 3 reserved) |
| pg_rdata | output | 4 | Page register read-back |
| wrp_we | input | 1 | Load working-register page |
| wrp_wdata | input | 4 | Working-register page value |
| wr_we | input | 1 | Working-register write enable |
| wr_idx | input | 4 | Working-register index |
| wr_wdata | input | 4 | Working-register write data |
| wr_rdata | output | 4 | Working-register read data |
| ind_we | input | 1 | Indirect write enable |
| ind_sel | input | 4 | Working register whose content is the low address nibble |
| ind_wdata | input | 4 | Indirect write data |
| ind_rdata | output | 4 | Indirect read data |
| ind_err | output | 1 | Indirect address out of range |
| dir_we | input | 1 | Direct write enable |
| dir_off | input | 7 | Offset within the selected bank |
| dir_wdata | input | 4 | Direct write data |
| dir_rdata | output | 4 | Direct read data |
| dir_err | output | 1 | Direct address out of range |

## Verification
The assertions check four things on every cycle: zero data returned whenever a port flags an error, the reserved page bit, the page register load and reset values, and a working-register write being readable one cycle later at the same index. Some behaviours need the stored contents of the whole array, so only the bench scenarios show them. These are the composition of indirect addresses through a working register's content, aliasing between the window and bank 0/1 words, write priority on a shared word, dropped out-of-range writes and old-data reads. The bench shows them by comparing every read port against a reference model across directed boundary cases and a long random run.

// File: rtl/nibble_dmem.sv
`timescale 1ns/1ps
module nibble_dmem #(
  parameter int DW      = 4,
  parameter int NBANK   = 40,
  parameter int BANK_W  = 128,
  parameter int PAGE_W  = 16,
  parameter int BKH_W   = 2,
  parameter int BKL_W   = 4,
  parameter int WRP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkh_we,
  input  logic [BKH_W-1:0] bkh_wdata,
  input  logic             bkl_we,
  input  logic [BKL_W-1:0] bkl_wdata,
  input  logic             pg_we,
  input  logic [3:0]       pg_wdata,
  output logic [3:0]       pg_rdata,
  input  logic             wrp_we,
  input  logic [WRP_W-1:0] wrp_wdata,
  input  logic             wr_we,
  input  logic [3:0]       wr_idx,
  input  logic [DW-1:0]    wr_wdata,
  output logic [DW-1:0]    wr_rdata,
  input  logic             ind_we,
  input  logic [3:0]       ind_sel,
  input  logic [DW-1:0]    ind_wdata,
  output logic [DW-1:0]    ind_rdata,
  output logic             ind_err,
  input  logic             dir_we,
  input  logic [6:0]       dir_off,
  input  logic [DW-1:0]    dir_wdata,
  output logic [DW-1:0]    dir_rdata,
  output logic             dir_err
);
  localparam int DEPTH = NBANK * BANK_W;
  localparam int OFF_W = $clog2(BANK_W);
  localparam int IDX_W = $clog2(PAGE_W);
  localparam int PGB_W = OFF_W - IDX_W;
  localparam int AW    = BKH_W + BKL_W + OFF_W;
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);
  localparam logic [3:0] PG_MASK = 4'((1 << PGB_W) - 1);

  logic [DW-1:0]    mem [0:DEPTH-1];
  logic [BKH_W-1:0] bkh_q;
  logic [BKL_W-1:0] bkl_q;
  logic [3:0]       pg_q;
  logic [WRP_W-1:0] wrp_q;

  logic [AW-1:0] wr_addr, sel_addr, ind_addr, dir_addr;
  logic [DW-1:0] sel_val;

  assign wr_addr  = AW'({wrp_q, wr_idx});
  assign sel_addr = AW'({wrp_q, ind_sel});
  assign sel_val  = mem[sel_addr];
  assign ind_addr = {bkh_q, bkl_q, pg_q[PGB_W-1:0], sel_val};
  assign dir_addr = {bkh_q, bkl_q, dir_off};

  assign ind_err   = ind_addr >= LIMIT;
  assign dir_err   = dir_addr >= LIMIT;
  assign ind_rdata = ind_err ? '0 : mem[ind_addr];
  assign dir_rdata = dir_err ? '0 : mem[dir_addr];
  assign wr_rdata  = mem[wr_addr];
  assign pg_rdata  = pg_q & PG_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkh_q <= '0;
      bkl_q <= '0;
      pg_q  <= '0;
      wrp_q <= '0;
    end else begin
      if (bkh_we) bkh_q <= bkh_wdata;
      if (bkl_we) bkl_q <= bkl_wdata;
      if (pg_we)  pg_q  <= pg_wdata;
      if (wrp_we) wrp_q <= wrp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (dir_we && !dir_err) mem[dir_addr] <= dir_wdata;
    if (ind_we && !ind_err) mem[ind_addr] <= ind_wdata;
    if (wr_we)              mem[wr_addr]  <= wr_wdata;
  end
endmodule

module nibble_dmem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pg_we,
  input logic [3:0] pg_wdata,
  input logic [3:0] pg_rdata,
  input logic       wrp_we,
  input logic       wr_we,
  input logic [3:0] wr_idx,
  input logic [3:0] wr_wdata,
  input logic [3:0] wr_rdata,
  input logic [3:0] ind_rdata,
  input logic       ind_err,
  input logic [3:0] dir_rdata,
  input logic       dir_err
);
  assert_ind_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ind_err |-> ind_rdata == 4'd0);
  assert_dir_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_err |-> dir_rdata == 4'd0);
  assert_page_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rdata[3] == 1'b0);
  assert_page_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |=> pg_rdata == {1'b0, $past(pg_wdata[2:0])});
  assert_page_reset_R7: assert property (@(posedge clk)
    !rst_n |=> pg_rdata == 4'd0);
  assert_wr_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we && !wrp_we) ##1 (wr_idx == $past(wr_idx)) |-> wr_rdata == $past(wr_wdata));
endmodule

bind nibble_dmem nibble_dmem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata),
  .wrp_we(wrp_we), .wr_we(wr_we), .wr_idx(wr_idx), .wr_wdata(wr_wdata),
  .wr_rdata(wr_rdata), .ind_rdata(ind_rdata), .ind_err(ind_err),
  .dir_rdata(dir_rdata), .dir_err(dir_err)
);

// File: tb/nibble_dmem_bench.sv
`timescale 1ns/1ps
module nibble_dmem_bench;
  logic clk = 0, rst_n = 0;
  logic bkh_we = 0, bkl_we = 0, pg_we = 0, wrp_we = 0, wr_we = 0, ind_we = 0, dir_we = 0;
  logic [1:0] bkh_wdata = 0;
  logic [3:0] bkl_wdata = 0, pg_wdata = 0, wrp_wdata = 0;
  logic [3:0] wr_idx = 0, wr_wdata = 0, ind_sel = 0, ind_wdata = 0, dir_wdata = 0;
  logic [6:0] dir_off = 0;
  logic [3:0] pg_rdata, wr_rdata, ind_rdata, dir_rdata;
  logic ind_err, dir_err;

  nibble_dmem u_nibble_dmem (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit auto_on = 0;
  logic [3:0] rm [0:5119];
  int m_bkh = 0, m_bkl = 0, m_pg = 0, m_wrp = 0;

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int e_ind();
    return m_bkh*2048 + m_bkl*128 + (m_pg & 7)*16 + int'(rm[m_wrp*16 + int'(ind_sel)]);
  endfunction
  function automatic int e_dir();
    return m_bkh*2048 + m_bkl*128 + int'(dir_off);
  endfunction
  function automatic logic [3:0] rd(int a);
    return (a >= 5120) ? 4'd0 : rm[a];
  endfunction

  task automatic cycle();
    int ia, da, wa;
    #1;
    ia = e_ind(); da = e_dir(); wa = m_wrp*16 + int'(wr_idx);
    if (auto_on) begin
      chk("R4 wr_rdata", wr_rdata, rm[wa]);
      chk("R2 ind_rdata", ind_rdata, rd(ia));
      chk("R6 ind_err", {3'b0, ind_err}, {3'b0, ia >= 5120});
      chk("R1 dir_rdata", dir_rdata, rd(da));
      chk("R6 dir_err", {3'b0, dir_err}, {3'b0, da >= 5120});
      chk("R3 pg_rdata", pg_rdata, 4'(m_pg & 7));
    end
    @(posedge clk);
    if (dir_we && da < 5120) rm[da] = dir_wdata;
    if (ind_we && ia < 5120) rm[ia] = ind_wdata;
    if (wr_we) rm[wa] = wr_wdata;
    if (bkh_we) m_bkh = int'(bkh_wdata);
    if (bkl_we) m_bkl = int'(bkl_wdata);
    if (pg_we)  m_pg  = int'(pg_wdata);
    if (wrp_we) m_wrp = int'(wrp_wdata);
    @(negedge clk);
    {bkh_we, bkl_we, pg_we, wrp_we, wr_we, ind_we, dir_we} = '0;
  endtask

  task automatic set_regs(int h, int l, int p, int w);
    bkh_we = 1; bkh_wdata = 2'(h); bkl_we = 1; bkl_wdata = 4'(l);
    pg_we = 1; pg_wdata = 4'(p); wrp_we = 1; wrp_wdata = 4'(w);
    cycle();
  endtask

  task automatic wr_write(int i, int v);
    wr_we = 1; wr_idx = 4'(i); wr_wdata = 4'(v); cycle();
  endtask

  initial begin
    #(8ns * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7: registers cleared by reset
    #1;
    chk("R7 pg after reset", pg_rdata, 4'd0);
    dir_off = 7'h7F;
    #1;
    chk("R7 bank regs zero (dir_err)", {3'b0, dir_err}, 4'd0);
    @(negedge clk);

    for (int b = 0; b < 40; b++) begin
      set_regs(b / 16, b % 16, 0, 0);
      for (int o = 0; o < 128; o++) begin
        dir_we = 1; dir_off = 7'(o); dir_wdata = 4'($urandom);
        cycle();
      end
    end
    auto_on = 1;

    // R1/R6 boundary on direct port
    set_regs(2, 7, 7, 0);
    dir_off = 7'h7F; #1;
    chk("R1 last word in range", {3'b0, dir_err}, 4'd0);
    cycle();
    set_regs(2, 8, 7, 0);
    dir_off = 7'h00; #1;
    chk("R6 first word out of range", {3'b0, dir_err}, 4'd1);
    chk("R6 out-of-range read zero", dir_rdata, 4'd0);
    cycle();

    // R2: 2*800H + 7*80H + 7*10H + F = 13FFH
    set_regs(2, 7, 7, 0);
    wr_write(2, 15);
    ind_sel = 2; #1;
    chk("R2 ind 13FF no error", {3'b0, ind_err}, 4'd0);
    chk("R2 ind 13FF data", ind_rdata, rm[16'h13FF]);
    cycle();
    // R6: out-of-range write through indirect port dropped
    set_regs(3, 15, 7, 0);
    ind_we = 1; ind_wdata = 4'h9; cycle();
    set_regs(0, 0, 0, 0);
    for (int a = 0; a < 128; a++) begin
      dir_off = 7'(a); cycle();
    end

    // R5: aliasing in both directions
    set_regs(0, 0, 0, 5);
    wr_write(3, 10);
    dir_off = 7'h53; #1;
    chk("R5 WR to data bank0", dir_rdata, 4'hA);
    cycle();
    set_regs(0, 1, 0, 12);
    wr_write(4, 6);
    dir_off = 7'h44; #1;
    chk("R5 WR to data bank1", dir_rdata, 4'h6);
    cycle();
    dir_we = 1; dir_off = 7'h47; dir_wdata = 4'h9; cycle();
    wr_idx = 7; #1;
    chk("R5 data to WR", wr_rdata, 4'h9);
    cycle();

    // R8: WR write and indirect read of the same word
    set_regs(0, 0, 0, 0);
    wr_write(1, 5);
    wr_write(5, 3);
    ind_sel = 1; wr_we = 1; wr_idx = 5; wr_wdata = 4'hC; #1;
    chk("R8 same-cycle read old", ind_rdata, 4'h3);
    cycle();
    #1;
    chk("R8 next-cycle read new", ind_rdata, 4'hC);
    cycle();

    // R9: collision priority
    dir_we = 1; dir_off = 7'h05; dir_wdata = 4'h1;
    wr_we = 1; wr_idx = 5; wr_wdata = 4'h8; cycle();
    #1;
    chk("R9 WR beats direct", dir_rdata, 4'h8);
    cycle();
    dir_we = 1; dir_off = 7'h05; dir_wdata = 4'h2;
    ind_we = 1; ind_sel = 1; ind_wdata = 4'h7; cycle();
    #1;
    chk("R9 indirect beats direct", dir_rdata, 4'h7);
    cycle();

    // R10: page write and indirect read in one cycle
    wr_write(1, 0);
    pg_we = 1; pg_wdata = 4'h2; ind_sel = 1; #1;
    chk("R10 old page used", ind_rdata, rm[0]);
    cycle();
    #1;
    chk("R10 new page used", ind_rdata, rm[32]);
    cycle();

    // R3: reserved bit
    pg_we = 1; pg_wdata = 4'hF; cycle();
    #1;
    chk("R3 reserved bit reads 0", pg_rdata, 4'h7);
    cycle();

    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 8 == 0) begin bkh_we = 1; bkh_wdata = 2'($urandom); end
      if ($urandom % 8 == 0) begin bkl_we = 1; bkl_wdata = 4'($urandom); end
      if ($urandom % 8 == 0) begin pg_we = 1; pg_wdata = 4'($urandom); end
      if ($urandom % 8 == 0) begin wrp_we = 1; wrp_wdata = 4'($urandom); end
      wr_we = 1'($urandom); wr_idx = 4'($urandom); wr_wdata = 4'($urandom);
      ind_we = 1'($urandom); ind_sel = 4'($urandom); ind_wdata = 4'($urandom);
      dir_we = 1'($urandom); dir_off = 7'($urandom); dir_wdata = 4'($urandom);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule